// File: doc/BRIEF.md
# Burst-of-Four DDR SRAM Controller

This block sits between an on-chip requester and an external common-I/O, double-data-rate synchronous SRAM whose bursts are always four beats long. A requester hands over one burst at a time on a valid/ready port: a write carries four data lanes and their byte enables, and a read returns four lanes as a single response. On the memory side the controller drives the clock level, a load strobe, a read/write select, the burst address and active-low byte-write enables. It also drives the shared data bus through a separate output, output-enable and input triple.

The block runs on a clock at twice the memory clock rate. Each tick is therefore one half period of the memory clock, and the data beats can be placed on the exact half-cycle edges the memory expects. Lane `j` of the user data always belongs to burst offset `j`. The memory's two-bit burst counter starts at the low address bits and wraps, so the controller rotates lanes on the way out and on the way back.

A sleep request stops the memory clock once nothing is in flight. The memory-side pins then keep their values until the request is withdrawn.

Top module: `sram_burst4_ctrl`

## Requirements
- R1: While reset (synchronous, active low) is applied, and on the first tick after it, `mem_ld_n` is 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `sleep_ack` is 0. Any bursts that were in flight are abandoned.
- R2: A request accepted at the clock edge that ends tick T puts the command on the pins for ticks T+1 and T+2 (`mem_ld_n` = 0). Tick T+1 is a tick where `mem_k` = 1. In every other tick `mem_ld_n` is 1.
- R3: During the command ticks, `mem_rw` is 1 for a read and 0 for a write, and `mem_addr` equals `req_addr`.
- R4: Call the first command tick C and let `o = req_addr[1:0]`. For a write, beat k (k = 0..3) is driven in tick C+2+k. It carries `req_wdata` lane `(o+k) mod 4`, where lane j is bits `[16j+15:16j]`. `mem_bw_n` is the bitwise inverse of `req_be` lane `(o+k) mod 4`, where lane j is bits `[2j+1:2j]`.
- R5: For a read, the value on `mem_dq_in` in tick C+3+k is the data for offset `(o+k) mod 4`. `rsp_valid` is 1 in tick C+7 only. In that tick `rsp_rdata` lane j holds the data for offset j.
- R6: Two consecutive commands start at least 4 ticks apart, which is two memory cycles.
- R7: A write that follows a read starts at least 6 ticks after that read, so its first beat never meets the read's last beat on the bus.
- R8: `mem_dq_oe` is 1 exactly in the ticks that carry write beats and is 0 otherwise.
- R9: `sleep_ack` rises only after every in-flight burst has finished, including the read response. `req_ready` is 0 while `sleep_req` is 1.
- R10: While `sleep_ack` is 1, `mem_k`, `mem_ld_n`, `mem_rw`, `mem_addr`, `mem_bw_n` and `mem_dq_oe` hold their values.
- R11: One tick after `sleep_req` falls, `sleep_ack` is 0 and requests are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Burst start address |
| req_wdata | input | 4*DW | Write data, lane j = offset j |
| req_be | input | 4*DW/8 | Byte enables, active high, lane j = offset j |
| rsp_valid | output | 1 | One-tick read response strobe |
| rsp_rdata | output | 4*DW | Read data, lane j = offset j |
| sleep_req | input | 1 | Ask to stop the memory clock |
| sleep_ack | output | 1 | Memory clock stopped |
| mem_k | output | 1 | Memory clock level |
| mem_ld_n | output | 1 | Load strobe, active low |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Burst address |
| mem_bw_n | output | DW/8 | Byte-write enables, active low |
| mem_dq_out | output | DW | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data bus sampled value |

## Verification
The bench aims at start addresses with nonzero low bits. A controller that skips the lane rotation writes the beats to the wrong offsets and returns a response whose lanes are shuffled. It also issues a read straight after a write, and a write straight after a read. The second case exposes a scheduler that ignores the turnaround: it drives the bus while the memory is still returning read data. A partial byte-enable write and an all-disabled write show whether `mem_bw_n` follows the right lane. A sleep request raised while a read is in flight catches a controller that stops the clock early and loses the response. A reset applied in the middle of a write burst catches a design that leaves the bus driven afterwards.

// File: rtl/sram4_pkg.sv
// Shared constants for the burst-of-four SRAM controller.
// All ages count ticks (half memory cycles) from the first command tick.
package sram4_pkg;
    localparam int BEATS = 4;
    typedef logic [1:0] off_t;
    typedef logic [2:0] age_t;
    // Age at which the command strobe is released after this tick.
    localparam age_t AGE_CMD_LAST  = 3'd1;
    // Write beats are loaded at the end of ticks aged 1..4.
    localparam age_t AGE_WR_FIRST  = 3'd1;
    localparam age_t AGE_WR_LOAD_E = 3'd4;
    localparam age_t AGE_WR_END    = 3'd5;
    // Read beats are sampled at the end of ticks aged 3..6.
    localparam age_t AGE_RD_FIRST  = 3'd3;
    localparam age_t AGE_RD_LAST   = 3'd6;
    // Minimum tick age of the last command before a new accept.
    localparam age_t GAP_ANY       = 3'd3;
    localparam age_t GAP_RD_TO_WR  = 3'd5;
    localparam age_t AGE_SAT       = 3'd7;
endpackage

// File: rtl/sram4_issue.sv
// Command issue and clock-stop control.
// Accepts a request only at an edge after which the memory clock is high,
// enforces command spacing and read-to-write turnaround, drives the load
// strobe, select and address, and freezes the memory clock on sleep.
// Assumes the slots report busy until their last data tick has ended.
module sram4_issue
    import sram4_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic          sleep_req,
    input  logic          busy,
    output logic          req_ready,
    output logic          accept,
    output logic          mem_k,
    output logic          mem_ld_n,
    output logic          mem_rw,
    output logic [AW-1:0] mem_addr,
    output logic          sleep_ack
);
    age_t since_cmd;   // ticks elapsed since the last command tick began
    logic last_rd;     // last command was a read
    logic gap_ok;

    // Spacing rule: 2 memory cycles, 3 after a read when writing.
    always_comb begin
        gap_ok = (since_cmd >= GAP_ANY) &&
                 (!(last_rd && req_write) || (since_cmd >= GAP_RD_TO_WR));
    end

    // Ready only in a low clock half with the bus schedule clear.
    always_comb begin
        req_ready = !sleep_ack && !sleep_req && !mem_k && gap_ok;
        accept    = req_valid && req_ready;
    end

    // Clock level, command pins and spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_k     <= 1'b0;
            mem_ld_n  <= 1'b1;
            mem_rw    <= 1'b1;
            mem_addr  <= '0;
            since_cmd <= AGE_SAT;
            last_rd   <= 1'b0;
        end else if (!sleep_ack) begin
            mem_k <= !mem_k;
            if (accept) begin
                mem_ld_n  <= 1'b0;
                mem_rw    <= !req_write;
                mem_addr  <= req_addr;
                last_rd   <= !req_write;
                since_cmd <= '0;
            end else begin
                if (since_cmd == AGE_CMD_LAST) mem_ld_n <= 1'b1;
                if (since_cmd != AGE_SAT) since_cmd <= since_cmd + 3'd1;
            end
        end
    end

    // Enter stop when idle, leave as soon as the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) sleep_ack <= 1'b0;
        else if (sleep_ack) sleep_ack <= sleep_req;
        else sleep_ack <= sleep_req && !busy && mem_ld_n;
    end

    // R2
    cmd_on_khi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ld_n) |-> mem_k);
    // R9
    stop_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> (!busy && mem_ld_n));
    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && $past(sleep_ack)) |->
            ($stable(mem_k) && $stable(mem_ld_n) && $stable(mem_addr) && $stable(mem_rw)));
    // R9
    sleep_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !accept);
endmodule

// File: rtl/sram4_slot.sv
// One in-flight burst tracker.
// Holds a burst from accept until its last data tick. For a write it
// shifts four beats onto the bus in rotated lane order. For a read it
// places the four sampled beats into offset order and pulses done.
// Assumes it is not reloaded within 8 ticks of its previous load.
module sram4_slot
    import sram4_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic              ld_write,
    input  off_t              ld_off,
    input  logic [4*DW-1:0]   ld_wdata,
    input  logic [4*BW-1:0]   ld_be,
    input  logic [DW-1:0]     dq_in,
    output logic              act,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    output logic [BW-1:0]     bw_n,
    output logic              done,
    output logic [4*DW-1:0]   data
);
    logic            is_wr;
    age_t            age;
    off_t            off;
    logic [4*BW-1:0] be_q;
    off_t            wlane, rlane;
    logic            wr_step, rd_step;

    // Lane selection from start offset and beat number.
    always_comb begin
        wlane   = off + off_t'(age - AGE_WR_FIRST);
        rlane   = off + off_t'(age - AGE_RD_FIRST);
        wr_step = act && is_wr && (age >= AGE_WR_FIRST) && (age <= AGE_WR_LOAD_E);
        rd_step = act && !is_wr && (age >= AGE_RD_FIRST) && (age <= AGE_RD_LAST);
    end

    // Burst life cycle: load, age, drive or capture, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            is_wr <= 1'b0;
            age   <= '0;
            off   <= '0;
            dq_oe <= 1'b0;
            bw_n  <= '1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                act   <= 1'b1;
                is_wr <= ld_write;
                age   <= '0;
                off   <= ld_off;
                data  <= ld_wdata;
                be_q  <= ld_be;
            end else if (act && adv) begin
                age <= age + 3'd1;
                if (wr_step) begin
                    dq_out <= data[wlane*DW +: DW];
                    bw_n   <= ~be_q[wlane*BW +: BW];
                    dq_oe  <= 1'b1;
                end
                if (is_wr && age == AGE_WR_END) begin
                    dq_oe <= 1'b0;
                    bw_n  <= '1;
                    act   <= 1'b0;
                end
                if (rd_step) data[rlane*DW +: DW] <= dq_in;
                if (!is_wr && age == AGE_RD_LAST) begin
                    done <= 1'b1;
                    act  <= 1'b0;
                end
            end
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    oe_wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> is_wr);
endmodule

// File: rtl/sram_burst4_ctrl.sv
// Burst-of-four DDR SRAM controller top.
// Runs on a clock at twice the memory rate. Rotates user lanes to the
// memory's wrapping burst order, alternates bursts over NSLOT trackers
// and merges their bus drive and read responses.
// Assumes NSLOT >= 2 so overlapping bursts always find a free tracker.
module sram_burst4_ctrl
    import sram4_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int NSLOT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [AW-1:0]         req_addr,
    input  logic [4*DW-1:0]       req_wdata,
    input  logic [4*(DW/8)-1:0]   req_be,
    output logic                  rsp_valid,
    output logic [4*DW-1:0]       rsp_rdata,
    input  logic                  sleep_req,
    output logic                  sleep_ack,
    output logic                  mem_k,
    output logic                  mem_ld_n,
    output logic                  mem_rw,
    output logic [AW-1:0]         mem_addr,
    output logic [DW/8-1:0]       mem_bw_n,
    output logic [DW-1:0]         mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DW-1:0]         mem_dq_in
);
    localparam int BW = DW / 8;
    localparam int PW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic              accept;
    logic              busy;
    logic [PW-1:0]     ptr;
    logic [NSLOT-1:0]  s_act, s_oe, s_done;
    logic [DW-1:0]     s_dq   [NSLOT];
    logic [BW-1:0]     s_bw   [NSLOT];
    logic [4*DW-1:0]   s_data [NSLOT];

    sram4_issue #(.AW(AW)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .sleep_req (sleep_req),
        .busy      (busy),
        .req_ready (req_ready),
        .accept    (accept),
        .mem_k     (mem_k),
        .mem_ld_n  (mem_ld_n),
        .mem_rw    (mem_rw),
        .mem_addr  (mem_addr),
        .sleep_ack (sleep_ack)
    );

    // Round-robin tracker pointer, advanced on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (accept) ptr <= (ptr == PW'(NSLOT - 1)) ? '0 : ptr + 1'b1;
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        sram4_slot #(.DW(DW), .BW(BW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (!sleep_ack),
            .load     (accept && (ptr == PW'(i))),
            .ld_write (req_write),
            .ld_off   (req_addr[1:0]),
            .ld_wdata (req_wdata),
            .ld_be    (req_be),
            .dq_in    (mem_dq_in),
            .act      (s_act[i]),
            .dq_out   (s_dq[i]),
            .dq_oe    (s_oe[i]),
            .bw_n     (s_bw[i]),
            .done     (s_done[i]),
            .data     (s_data[i])
        );
    end

    // Merge tracker bus drive and read responses.
    always_comb begin
        mem_dq_out = '0;
        mem_dq_oe  = 1'b0;
        mem_bw_n   = '1;
        rsp_valid  = 1'b0;
        rsp_rdata  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (s_oe[i]) begin
                mem_dq_out = mem_dq_out | s_dq[i];
                mem_bw_n   = mem_bw_n & s_bw[i];
                mem_dq_oe  = 1'b1;
            end
            if (s_done[i]) begin
                rsp_valid = 1'b1;
                rsp_rdata = rsp_rdata | s_data[i];
            end
        end
        busy = |s_act;
    end

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_oe));
    // R5
    one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_done));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (mem_ld_n && !mem_dq_oe && !rsp_valid && !sleep_ack));
endmodule

// File: tb/sram_burst4_ctrl_tb.sv
module sram_burst4_ctrl_tb;
    localparam int PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int BW = 2;
    localparam int NV = 11;
    // {write, addr, wdata, be}
    localparam logic [80:0] VEC [NV] = '{
        {1'b1, 8'h10, 64'h4444_3333_2222_1111, 8'hFF},
        {1'b1, 8'h17, 64'hDDDD_CCCC_BBBB_AAAA, 8'hFF},
        {1'b0, 8'h10, 64'h0, 8'h00},
        {1'b0, 8'h17, 64'h0, 8'h00},
        {1'b1, 8'h22, 64'h8877_6655_4433_2211, 8'hA5},
        {1'b0, 8'h22, 64'h0, 8'h00},
        {1'b0, 8'h40, 64'h0, 8'h00},
        {1'b1, 8'h41, 64'h0F0F_0E0E_0D0D_0C0C, 8'hFF},
        {1'b0, 8'h41, 64'h0, 8'h00},
        {1'b1, 8'h12, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00},
        {1'b0, 8'h12, 64'h0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [4*DW-1:0] req_wdata = '0;
    logic [4*BW-1:0] req_be = '0;
    logic sleep_req = 1'b0;
    logic [DW-1:0] mem_dq_in = '0;
    logic req_ready, rsp_valid, sleep_ack, mem_k, mem_ld_n, mem_rw, mem_dq_oe;
    logic [4*DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_bw_n;
    logic [DW-1:0] mem_dq_out;

    int total = 0, bad = 0, tk = 0;
    int exp_c = -100, last_c = -100, last_rd_c = -100;
    logic pend_wr;
    logic [AW-1:0] pend_addr;
    logic [4*DW-1:0] pend_wd;
    logic [4*BW-1:0] pend_be;

    logic [DW-1:0] model [256];
    logic wsch [16], rsch [16], psch [16];
    logic [DW-1:0] wd_e [16], rd_v [16];
    logic [BW-1:0] wb_e [16];
    logic [4*DW-1:0] pd_e [16];

    sram_burst4_ctrl #(.AW(AW), .DW(DW), .NSLOT(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sleep_req(sleep_req), .sleep_ack(sleep_ack), .mem_k(mem_k),
        .mem_ld_n(mem_ld_n), .mem_rw(mem_rw), .mem_addr(mem_addr),
        .mem_bw_n(mem_bw_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (tick %0d)", req, act, exp, tk);
        end
    endtask

    function automatic logic [AW-1:0] lane_addr(input logic [AW-1:0] a, input int j);
        return {a[AW-1:2], 2'(j)};
    endfunction

    // Memory model and pin monitor: one pass per tick at mid-tick.
    always @(negedge clk) begin
        tk++;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                wsch[i] = 1'b0; rsch[i] = 1'b0; psch[i] = 1'b0;
            end
            mem_dq_in = '0;
            last_c = -100; last_rd_c = -100;
        end else begin
            int idx;
            idx = tk % 16;
            // R8: drive enable only in write-beat ticks
            chk(mem_dq_oe === wsch[idx], "R8 oe", 64'(mem_dq_oe), 64'(wsch[idx]));
            if (wsch[idx]) begin
                chk(mem_dq_out === wd_e[idx], "R4 data", 64'(mem_dq_out), 64'(wd_e[idx]));
                chk(mem_bw_n === wb_e[idx], "R4 bw_n", 64'(mem_bw_n), 64'(wb_e[idx]));
            end
            mem_dq_in = rsch[idx] ? rd_v[idx] : '0;
            if (rsp_valid || psch[idx]) begin
                chk(rsp_valid === psch[idx], "R5 rsp_valid", 64'(rsp_valid), 64'(psch[idx]));
                chk(rsp_rdata === pd_e[idx], "R5 rsp_rdata", rsp_rdata, pd_e[idx]);
            end
            wsch[idx] = 1'b0; rsch[idx] = 1'b0; psch[idx] = 1'b0;
            if (!mem_ld_n && mem_k) begin
                int c;
                c = tk;
                chk(c == exp_c, "R2 cmd tick", 64'(c), 64'(exp_c));
                chk(mem_rw === !pend_wr, "R3 rw", 64'(mem_rw), 64'(!pend_wr));
                chk(mem_addr === pend_addr, "R3 addr", 64'(mem_addr), 64'(pend_addr));
                chk(c - last_c >= 4, "R6 spacing", 64'(c - last_c), 64'd4);
                if (pend_wr)
                    chk(c - last_rd_c >= 6, "R7 turnaround", 64'(c - last_rd_c), 64'd6);
                last_c = c;
                if (pend_wr) begin
                    for (int k = 0; k < 4; k++) begin
                        int j, s;
                        j = (int'(pend_addr[1:0]) + k) % 4;
                        s = (c + 2 + k) % 16;
                        wsch[s] = 1'b1;
                        wd_e[s] = pend_wd[j*DW +: DW];
                        wb_e[s] = ~pend_be[j*BW +: BW];
                        for (int b = 0; b < BW; b++)
                            if (pend_be[j*BW + b])
                                model[lane_addr(pend_addr, j)][b*8 +: 8] = pend_wd[j*DW + b*8 +: 8];
                    end
                end else begin
                    last_rd_c = c;
                    for (int k = 0; k < 4; k++) begin
                        int j, s;
                        j = (int'(pend_addr[1:0]) + k) % 4;
                        s = (c + 3 + k) % 16;
                        rsch[s] = 1'b1;
                        rd_v[s] = model[lane_addr(pend_addr, j)];
                        pd_e[(c + 7) % 16][j*DW +: DW] = model[lane_addr(pend_addr, j)];
                    end
                    psch[(c + 7) % 16] = 1'b1;
                end
            end
        end
    end

    task automatic issue(input logic [80:0] v);
        req_valid = 1'b1;
        req_write = v[80];
        req_addr  = v[79:72];
        req_wdata = v[71:8];
        req_be    = v[7:0];
        #1;
        while (!req_ready) begin
            @(negedge clk); #2;
        end
        pend_wr = v[80]; pend_addr = v[79:72]; pend_wd = v[71:8]; pend_be = v[7:0];
        exp_c = tk + 1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        #(PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] hk;
        logic hl, hr, ho;
        logic [AW-1:0] ha;
        logic [BW-1:0] hb;
        int c0;
        for (int i = 0; i < 256; i++) model[i] = 16'(i * 16'h0123 + 16'h5A5A);
        ticks(3);
        // R1: idle state under reset
        chk(mem_ld_n === 1'b1, "R1 ld_n", 64'(mem_ld_n), 64'd1);
        chk(mem_dq_oe === 1'b0, "R1 oe", 64'(mem_dq_oe), 64'd0);
        chk(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(sleep_ack === 1'b0, "R1 sleep_ack", 64'(sleep_ack), 64'd0);
        @(negedge clk); #1; rst_n = 1'b1;
        ticks(2);

        // Table walk: wrap offsets, partial enables, read/write turnarounds
        for (int v = 0; v < NV; v++) issue(VEC[v]);
        ticks(12);

        // R9: sleep with a read in flight
        issue({1'b0, 8'h22, 64'h0, 8'h00});
        c0 = exp_c;
        sleep_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h50;
        forever begin
            @(negedge clk); #2;
            if (tk < c0 + 8) begin
                chk(sleep_ack === 1'b0, "R9 early stop", 64'(sleep_ack), 64'd0);
                chk(req_ready === 1'b0, "R9 ready in sleep", 64'(req_ready), 64'd0);
            end else begin
                chk(sleep_ack === 1'b1, "R9 stop after drain", 64'(sleep_ack), 64'd1);
                break;
            end
        end
        req_valid = 1'b0;
        // R10: pins frozen while stopped
        hk = {7'd0, mem_k}; hl = mem_ld_n; hr = mem_rw; ho = mem_dq_oe; ha = mem_addr; hb = mem_bw_n;
        ticks(6);
        chk(mem_k === hk[0], "R10 k", 64'(mem_k), 64'(hk[0]));
        chk(mem_ld_n === hl && mem_rw === hr && mem_dq_oe === ho, "R10 ctl",
            64'({mem_ld_n, mem_rw, mem_dq_oe}), 64'({hl, hr, ho}));
        chk(mem_addr === ha && mem_bw_n === hb, "R10 addr", 64'({mem_addr, mem_bw_n}), 64'({ha, hb}));
        // R11: resume
        sleep_req = 1'b0;
        ticks(1);
        chk(sleep_ack === 1'b0, "R11 resume", 64'(sleep_ack), 64'd0);
        issue({1'b0, 8'h17, 64'h0, 8'h00});
        ticks(10);

        // R1: reset in the middle of a write burst
        issue({1'b1, 8'h31, 64'h1234_5678_9ABC_DEF0, 8'hFF});
        ticks(1);
        #1; rst_n = 1'b0;
        ticks(1);
        chk(mem_ld_n === 1'b1, "R1 ld_n mid-burst", 64'(mem_ld_n), 64'd1);
        chk(mem_dq_oe === 1'b0, "R1 oe mid-burst", 64'(mem_dq_oe), 64'd0);
        @(negedge clk); #1; rst_n = 1'b1;
        ticks(8);
        chk(mem_dq_oe === 1'b0, "R1 bus stays released", 64'(mem_dq_oe), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule